// File: doc/BRIEF.md
# Sense-Reversing Centralized Barrier

This block holds a group of participants at a common synchronization point until every one of them has arrived. It keeps a single arrival tally and a single shared release flag. Each participant also keeps a private sense bit. An accepted arrival flips that participant's sense bit and adds one to the tally. A participant waits for as long as its sense differs from the shared flag.

When the tally reaches the participant count, the flag inverts and the tally returns to zero. The inverted flag now matches the sense of every participant, so all of them are released together. Because the flag alternates between episodes, a participant that re-enters at once is held by the next episode. It cannot slip through the one that just ended, and no second counter or drain phase is needed.

Arrival strobes from several participants in the same cycle are all counted in that cycle. An arrival from a participant that is already waiting is refused and reported on an error pulse.

Top module: `sense_barrier`

## Requirements
- R1: After reset, all release outputs are high, the tally is zero, and the done and error outputs are low.
- R2: An arrive strobe from a released participant that does not complete the episode drives that participant's release output low from the next cycle.
- R3: A waiting participant's release output stays low until the cycle after the arrival that completes the episode.
- R4: When the accepted arrivals of an episode reach the participant count, every release output is high in the next cycle and the tally restarts from zero.
- R5: Arrive strobes from several participants in one cycle are all counted in that cycle. If the strobes come from every participant together, the episode completes at once.
- R6: The done output is high for exactly one cycle after each completing edge. It is low in every other cycle, including while an episode is only partly filled.
- R7: An arrive strobe from a participant that is waiting raises the error output for one cycle and is not counted. The episode still needs one arrival from each of the other participants.
- R8: A participant may arrive again in the first cycle after its release. That arrival belongs to the new episode and is held until all participants have arrived again.
- R9: The error output is high only in the cycle after a refused arrival.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| arrive | input | NUM_PARTS | One arrival strobe per participant, one cycle per arrival |
| release_o | output | NUM_PARTS | High when the participant's sense equals the shared flag |
| done_o | output | 1 | One-cycle pulse after an episode completes |
| err_o | output | 1 | One-cycle pulse after an arrival from a waiting participant |

## Verification
A wrong tally shows up as an episode that completes early or late. Release rises and done pulses one cycle off from the expected arrival, and the difference is visible on the first episode in which the count is disturbed. A flipped sense bit or flag appears at once as a wrong release bit in the next cycle. It also shows on later arrivals, which are then refused or accepted wrongly, so the error pulse shows the fault within one episode.

// File: rtl/barrier_sync_pkg.sv
// Package: shared helpers for the barrier.
// Assumes participant vectors no wider than 64 bits.
package barrier_sync_pkg;

    localparam int unsigned MAX_PARTS = 64;

    // Population count of the low n bits of v.
    function automatic int unsigned ones_in(input logic [MAX_PARTS-1:0] v,
                                            input int unsigned n);
        int unsigned acc;
        acc = 0;
        for (int unsigned k = 0; k < MAX_PARTS; k++) begin
            if (k < n && v[k]) acc++;
        end
        return acc;
    endfunction

endpackage

// File: rtl/bsb_sense_slot.sv
// Module: bsb_sense_slot
// Per-participant sense register. It accepts an arrival only while the
// participant is released, flips its sense on acceptance and reports a
// refused arrival. Assumes flag_i is the shared release flag register.
module bsb_sense_slot (
    input  logic clk,
    input  logic rst_n,
    input  logic arrive_i,
    input  logic flag_i,
    input  logic complete_i,
    output logic waiting_o,
    output logic accept_o,
    output logic refuse_o
);
    logic sense_q;

    // Waiting while private sense differs from the shared flag.
    always_comb begin
        waiting_o = sense_q ^ flag_i;
        accept_o  = arrive_i & ~waiting_o;
        refuse_o  = arrive_i & waiting_o;
    end

    // Flip private sense on each accepted arrival.
    always_ff @(posedge clk) begin
        if (!rst_n) sense_q <= 1'b0;
        else if (accept_o) sense_q <= ~sense_q;
    end

    // R2: a non-final accepted arrival leaves the participant waiting.
    a_r2_enter_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_o && !complete_i) |=> waiting_o);

    // R3: a waiter stays waiting until the completing edge.
    a_r3_hold_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting_o && !complete_i) |=> waiting_o);

    // R4: completion releases this participant.
    a_r4_release_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        complete_i |=> !waiting_o);
endmodule

// File: rtl/bsb_arrival_tally.sv
// Module: bsb_arrival_tally
// Shared arrival counter. It adds the population count of the accepted
// arrivals each cycle and flags completion when the sum hits NUM_PARTS.
// Assumes each participant is accepted at most once per episode.
module bsb_arrival_tally
    import barrier_sync_pkg::*;
#(
    parameter int unsigned NUM_PARTS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PARTS-1:0] accepted_i,
    output logic                 complete_o
);
    localparam int unsigned CW = $clog2(NUM_PARTS + 1);
    localparam int unsigned SW = CW + 1;

    logic [CW-1:0] count_q;
    logic [SW-1:0] sum;
    logic [MAX_PARTS-1:0] acc_wide;

    // Sum of the current tally and this cycle's accepted arrivals.
    always_comb begin
        acc_wide = '0;
        acc_wide[NUM_PARTS-1:0] = accepted_i;
        sum = SW'(count_q) + SW'(ones_in(acc_wide, NUM_PARTS));
        complete_o = (sum == SW'(NUM_PARTS));
    end

    // Update tally, restarting at zero on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else if (complete_o) count_q <= '0;
        else count_q <= sum[CW-1:0];
    end

    // R5: tally never reaches or passes the participant count.
    a_r5_tally_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count_q < CW'(NUM_PARTS));

    // R4: tally restarts after completion.
    a_r4_tally_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        complete_o |=> (count_q == '0));
endmodule

// File: rtl/sense_barrier.sv
// Module: sense_barrier (top)
// Centralized barrier with sense reversal. It holds one shared flag that
// inverts on each completed episode, registers the done and error pulses,
// and drives release outputs from the per-participant sense slots.
// Assumes arrive strobes are synchronous to clk.
module sense_barrier #(
    parameter int unsigned NUM_PARTS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PARTS-1:0] arrive,
    output logic [NUM_PARTS-1:0] release_o,
    output logic                 done_o,
    output logic                 err_o
);
    logic                 flag_q;
    logic                 complete;
    logic [NUM_PARTS-1:0] waiting;
    logic [NUM_PARTS-1:0] accepted;
    logic [NUM_PARTS-1:0] refused;

    for (genvar g = 0; g < NUM_PARTS; g++) begin : g_slot
        bsb_sense_slot u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .arrive_i   (arrive[g]),
            .flag_i     (flag_q),
            .complete_i (complete),
            .waiting_o  (waiting[g]),
            .accept_o   (accepted[g]),
            .refuse_o   (refused[g])
        );
    end

    bsb_arrival_tally #(.NUM_PARTS(NUM_PARTS)) u_tally (
        .clk        (clk),
        .rst_n      (rst_n),
        .accepted_i (accepted),
        .complete_o (complete)
    );

    // Release whenever a participant's sense matches the flag.
    always_comb release_o = ~waiting;

    // Invert the shared flag on completion; register the pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            done_o <= 1'b0;
            err_o  <= 1'b0;
        end else begin
            if (complete) flag_q <= ~flag_q;
            done_o <= complete;
            err_o  <= |refused;
        end
    end

    // R4: a done pulse coincides with every participant released.
    a_r4_done_all_free: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (&release_o));

    // R7: a refused arrival yields an error pulse.
    a_r7_refuse_err: assert property (@(posedge clk) disable iff (!rst_n)
        (|(arrive & ~release_o)) |=> err_o);

    // R9: no error pulse without a refused arrival.
    a_r9_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(arrive & ~release_o)) |=> !err_o);

    // R6: done only follows a flag inversion.
    a_r6_done_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (done_o == (flag_q != $past(flag_q))));
endmodule

// File: tb/test_sense_barrier.sv
module test_sense_barrier;
    localparam int unsigned NP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] arrive = '0;
    logic [NP-1:0] release_o;
    logic          done_o, err_o;

    int n_tests = 0;
    int n_fail  = 0;

    logic [NP-1:0] m_sense;
    logic          m_flag;
    int unsigned   m_cnt;
    logic          m_done, m_err;

    always #2 clk = ~clk;

    sense_barrier #(.NUM_PARTS(NP)) i_sense_barrier (
        .clk(clk), .rst_n(rst_n), .arrive(arrive),
        .release_o(release_o), .done_o(done_o), .err_o(err_o)
    );

    function automatic logic [NP-1:0] exp_release();
        return ~(m_sense ^ {NP{m_flag}});
    endfunction

    function automatic int unsigned pop(input logic [NP-1:0] v);
        int unsigned c = 0;
        for (int k = 0; k < NP; k++) c += v[k];
        return c;
    endfunction

    task automatic check(input string tag);
        n_tests++;
        if (release_o !== exp_release() || done_o !== m_done || err_o !== m_err) begin
            n_fail++;
            $display("FAIL %s: release=%b done=%b err=%b expected release=%b done=%b err=%b",
                     tag, release_o, done_o, err_o, exp_release(), m_done, m_err);
        end
    endtask

    // Drive one cycle of arrivals, advance the model, check after the edge.
    task automatic step(input logic [NP-1:0] arr, input string tag);
        logic [NP-1:0] acc, bad;
        @(negedge clk);
        arrive = arr;
        acc = arr & exp_release();
        bad = arr & ~exp_release();
        @(posedge clk);
        #1;
        arrive = '0;
        m_sense = m_sense ^ acc;
        m_cnt   = m_cnt + pop(acc);
        m_done  = 1'b0;
        if (m_cnt == NP) begin
            m_cnt  = 0;
            m_flag = ~m_flag;
            m_done = 1'b1;
        end
        m_err = |bad;
        check(tag);
    endtask

    initial begin : watchdog
        #400000;
        n_fail++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        m_sense = '0; m_flag = 1'b0; m_cnt = 0; m_done = 1'b0; m_err = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset state");

        // R2 / R3: one-by-one arrivals
        step(4'b0001, "R2 first arrival waits");
        step(4'b0000, "R3 waiter holds");
        step(4'b0100, "R2 second arrival");
        // R7 / R9: rearrival while waiting is refused
        step(4'b0001, "R7 rearrival refused");
        step(4'b0000, "R9 error clears");
        step(4'b0010, "R3 third arrival");
        step(4'b1000, "R4 last arrival releases all");
        step(4'b0000, "R6 done lasts one cycle");
        // R5: all at once
        step(4'b1111, "R5 simultaneous completion");
        // R8: back-to-back reuse
        step(4'b0011, "R8 immediate reentry held");
        step(4'b0011, "R7 reentered pair refused");
        step(4'b1100, "R8 second episode completes");
        step(4'b1111, "R8 third episode right after");
        // R5 mixed refusal and acceptance in one cycle
        step(4'b0110, "R5 pair arrives");
        step(4'b1111, "R7 mixed accept and refuse");
        step(4'b0000, "R6 idle after completion");

        for (int i = 0; i < 3000; i++) begin
            logic [NP-1:0] r;
            r = NP'($urandom) & NP'($urandom);
            step(r, "R4 random episode");
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule